// File: doc/BRIEF.md
# Microprogram Sequencer with Next-Address Field

This block steps through microinstructions for a microprogrammed control unit. A 6-bit microprogram counter addresses a 64-word control store that is filled when the design is built. Every control word holds three binary-encoded signal groups (ALU function, bus source, load destination), a memory-operation group, a sequencing field, a condition selector, an OR-enable flag and a next-address field. The encoded groups are expanded into one-hot control lines at the outputs, together with an end-of-instruction flag and the current counter value.

The counter update follows from the sequencing field of the word being issued. The four sequencing kinds are SQ_INC (step to the following word), SQ_JMP (go to the next-address field), SQ_BR (go to the next-address field only if the selected condition flag is 1, else step) and SQ_END (return to the fetch routine at word 0). A new-instruction strobe overrides all four and loads the start address of the opcode's microroutine. When the issued word's OR flag is set, the two addressing-mode bits are OR-ed into the low bits of the jump target, the branch target or the start address. Routines can therefore skip words for some modes without spending a branch word. A stall input freezes the counter.

Top module: `microseq`

## Requirements
- R1: While reset is held and directly after it is released, upc is 0 and the fetch word 0 is issued: mem_rd=1, src_oe=7'b0000001, dst_ld=7'b0000001, alu_op=0, end_instr=0.
- R2: With stall=0 and instr_load=0, a word whose sequencing kind is SQ_INC is followed on the next clock edge by upc+1.
- R3: With stall=0, instr_load=1 loads upc with opcode*4 on the next edge, whatever the issued word's sequencing kind is. When the issued word's OR flag is set, mode is OR-ed into bits [1:0] of that address.
- R4: An SQ_JMP word loads its next-address field. When its OR flag is set, the live mode bits are OR-ed into bits [1:0].
- R5: An SQ_BR word selects one bit of cond_flags by its 2-bit condition field. If that bit is 1, upc takes the next-address field. If it is 0, upc takes upc+1.
- R6: An SQ_END word drives end_instr=1, and the next edge returns upc to 0 unless instr_load is high.
- R7: While stall=1, upc holds its value and the outputs keep showing the same word. instr_load is ignored during that time.
- R8: Each 3-bit group (alu_op, src_oe, dst_ld) decodes code 0 to all lines low and code k to bit k-1 alone. The memory group decodes code 0 to none, 1 to mem_rd, 2 to mem_wr and 3 to mem_wait. mem_rd and mem_wr are never high together.
- R9: The fetch routine is as follows. Word 0 has src 1, dst 1, memory read and SQ_INC. Word 1 has memory wait and SQ_INC. Word 2 has src 2, dst 2, the OR flag and SQ_INC. Word 3 is SQ_END.
- R10: Opcode 1 has the following words. Word 4 has src 3, dst 3 and SQ_INC. Word 5 has alu 1, src 4, dst 4 and SQ_INC. Word 6 has src 5, dst 5 and SQ_END. Word 7 is SQ_END.
- R11: Opcode 2 has the following words. Word 8 is SQ_BR on flag 0 with target 12. Word 9 has alu 2, src 4, dst 4, memory write and SQ_END. Word 12 has src 5, dst 6 and SQ_END.
- R12: Word 16 is SQ_JMP to 20 with the OR flag set. Words 20 to 23 are SQ_END with dst code (address - 19). Words not listed here are all-zero no-operation SQ_INC words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| stall | input | 1 | Freezes the microprogram counter |
| instr_load | input | 1 | New instruction strobe, loads the start address |
| opcode | input | 4 | Opcode that selects the microroutine |
| mode | input | 2 | Addressing-mode bits for OR-ing into addresses |
| cond_flags | input | 4 | Condition flags tested by branch words |
| upc | output | 6 | Current microprogram counter |
| alu_op | output | 7 | One-hot ALU function lines |
| src_oe | output | 7 | One-hot bus source enables |
| dst_ld | output | 7 | One-hot destination load enables |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write request |
| mem_wait | output | 1 | Wait for memory completion |
| end_instr | output | 1 | Last microinstruction of the instruction |

## Verification
The hardest cases to reach from the ports are those where two next-address sources compete in one cycle. These are a new-instruction strobe on an SQ_END word, a strobe during a stall, and a jump whose OR bits come from a mode value different from the one seen at dispatch. Each directed task first walks the fetch routine to word 2 so that the dispatch happens under known OR-flag conditions. It then changes mode, cond_flags, stall or instr_load on the exact cycle the word of interest is issued. The branch test sets every condition flag except the selected one, so choosing the wrong flag changes the path that is taken.

// File: rtl/microseq_pkg.sv
`timescale 1ns/1ps
package microseq_pkg;
    localparam int UPC_W    = 6;
    localparam int CS_DEPTH = 1 << UPC_W;
    localparam int OPC_W    = 4;
    localparam int MODE_W   = 2;
    localparam int FLAG_W   = 4;
    localparam int CND_W    = $clog2(FLAG_W);
    localparam int GRP_W    = 3;
    localparam int GRP_N    = (1 << GRP_W) - 1;
    localparam int MEM_W    = 2;
    localparam int MEM_N    = (1 << MEM_W) - 1;
    localparam int START_SH = UPC_W - OPC_W;

    typedef enum logic [1:0] {
        SQ_INC = 2'd0,
        SQ_JMP = 2'd1,
        SQ_BR  = 2'd2,
        SQ_END = 2'd3
    } seq_e;

    typedef struct packed {
        seq_e              seq;
        logic [CND_W-1:0]  cond;
        logic              orm;
        logic [UPC_W-1:0]  nxt;
        logic [GRP_W-1:0]  alu;
        logic [GRP_W-1:0]  src;
        logic [GRP_W-1:0]  dst;
        logic [MEM_W-1:0]  mem;
    } cw_t;

    function automatic cw_t mk(seq_e s, int c, bit o, int n,
                               int a, int sr, int d, int m);
        cw_t w;
        w.seq  = s;
        w.cond = CND_W'(c);
        w.orm  = o;
        w.nxt  = UPC_W'(n);
        w.alu  = GRP_W'(a);
        w.src  = GRP_W'(sr);
        w.dst  = GRP_W'(d);
        w.mem  = MEM_W'(m);
        return w;
    endfunction

    function automatic cw_t cs_init(int addr);
        cw_t w;
        w = '0;
        case (addr)
            0:  w = mk(SQ_INC, 0, 1'b0, 0, 0, 1, 1, 1);
            1:  w = mk(SQ_INC, 0, 1'b0, 0, 0, 0, 0, 3);
            2:  w = mk(SQ_INC, 0, 1'b1, 0, 0, 2, 2, 0);
            3:  w = mk(SQ_END, 0, 1'b0, 0, 0, 0, 0, 0);
            4:  w = mk(SQ_INC, 0, 1'b0, 0, 0, 3, 3, 0);
            5:  w = mk(SQ_INC, 0, 1'b0, 0, 1, 4, 4, 0);
            6:  w = mk(SQ_END, 0, 1'b0, 0, 0, 5, 5, 0);
            7:  w = mk(SQ_END, 0, 1'b0, 0, 0, 0, 0, 0);
            8:  w = mk(SQ_BR,  0, 1'b0, 12, 0, 0, 0, 0);
            9:  w = mk(SQ_END, 0, 1'b0, 0, 2, 4, 4, 2);
            12: w = mk(SQ_END, 0, 1'b0, 0, 0, 5, 6, 0);
            16: w = mk(SQ_JMP, 0, 1'b1, 20, 0, 0, 0, 0);
            20, 21, 22, 23:
                w = mk(SQ_END, 0, 1'b0, 0, 0, 0, addr - 19, 0);
            default: w = '0;
        endcase
        return w;
    endfunction
endpackage

// File: rtl/useq_store.sv
`timescale 1ns/1ps
module useq_store
    import microseq_pkg::*;
(
    input  logic [UPC_W-1:0] addr,
    output cw_t              word
);
    cw_t rom [CS_DEPTH];

    for (genvar a = 0; a < CS_DEPTH; a++) begin : g_word
        assign rom[a] = cs_init(a);
    end

    assign word = rom[addr];
endmodule

// File: rtl/useq_decode.sv
`timescale 1ns/1ps
module useq_decode #(
    parameter int W = 3
) (
    input  logic [W-1:0]          code,
    output logic [(1<<W)-2:0]     lines
);
    localparam int N = (1 << W) - 1;

    for (genvar i = 0; i < N; i++) begin : g_line
        assign lines[i] = (code == W'(i + 1));
    end
endmodule

// File: rtl/useq_next.sv
`timescale 1ns/1ps
module useq_next
    import microseq_pkg::*;
(
    input  logic [UPC_W-1:0]  upc,
    input  cw_t               word,
    input  logic              instr_load,
    input  logic [OPC_W-1:0]  opcode,
    input  logic [MODE_W-1:0] mode,
    input  logic [FLAG_W-1:0] cond_flags,
    output logic [UPC_W-1:0]  nxt
);
    logic [UPC_W-1:0] or_bits;
    logic [UPC_W-1:0] target;
    logic [UPC_W-1:0] start;
    logic [UPC_W-1:0] step;

    always_comb begin
        or_bits = word.orm ? UPC_W'(mode) : '0;
        target  = word.nxt | or_bits;
        start   = (UPC_W'(opcode) << START_SH) | or_bits;
        step    = UPC_W'(upc + 1'b1);
        nxt     = step;
        if (instr_load) begin
            nxt = start;
        end else begin
            unique case (word.seq)
                SQ_INC: nxt = step;
                SQ_JMP: nxt = target;
                SQ_BR:  nxt = cond_flags[word.cond] ? target : step;
                SQ_END: nxt = '0;
            endcase
        end
    end
endmodule

// File: rtl/microseq.sv
`timescale 1ns/1ps
module microseq
    import microseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stall,
    input  logic              instr_load,
    input  logic [OPC_W-1:0]  opcode,
    input  logic [MODE_W-1:0] mode,
    input  logic [FLAG_W-1:0] cond_flags,
    output logic [UPC_W-1:0]  upc,
    output logic [GRP_N-1:0]  alu_op,
    output logic [GRP_N-1:0]  src_oe,
    output logic [GRP_N-1:0]  dst_ld,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              mem_wait,
    output logic              end_instr
);
    cw_t              cur_word;
    seq_e             cur_seq;
    logic [UPC_W-1:0] upc_q;
    logic [UPC_W-1:0] upc_d;
    logic [MEM_N-1:0] mem_lines;

    useq_store u_store (
        .addr (upc_q),
        .word (cur_word)
    );

    useq_next u_next (
        .upc        (upc_q),
        .word       (cur_word),
        .instr_load (instr_load),
        .opcode     (opcode),
        .mode       (mode),
        .cond_flags (cond_flags),
        .nxt        (upc_d)
    );

    // counter register: the only state of the sequencer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            upc_q <= '0;
        end else if (!stall) begin
            upc_q <= upc_d;
        end
    end

    useq_decode #(.W(GRP_W)) u_dec_alu (.code(cur_word.alu), .lines(alu_op));
    useq_decode #(.W(GRP_W)) u_dec_src (.code(cur_word.src), .lines(src_oe));
    useq_decode #(.W(GRP_W)) u_dec_dst (.code(cur_word.dst), .lines(dst_ld));
    useq_decode #(.W(MEM_W)) u_dec_mem (.code(cur_word.mem), .lines(mem_lines));

    // outputs
    always_comb begin
        cur_seq   = cur_word.seq;
        upc       = upc_q;
        mem_rd    = mem_lines[0];
        mem_wr    = mem_lines[1];
        mem_wait  = mem_lines[2];
        end_instr = 1'b0;
        unique case (cur_seq)
            SQ_INC, SQ_JMP, SQ_BR: end_instr = 1'b0;
            SQ_END:                end_instr = 1'b1;
        endcase
    end
endmodule

// File: rtl/microseq_chk.sv
`timescale 1ns/1ps
module microseq_chk
    import microseq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              stall,
    input logic              instr_load,
    input logic [OPC_W-1:0]  opcode,
    input logic [UPC_W-1:0]  upc,
    input logic [GRP_N-1:0]  alu_op,
    input logic [GRP_N-1:0]  src_oe,
    input logic [GRP_N-1:0]  dst_ld,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic              mem_wait,
    input logic              end_instr,
    input seq_e              seq_kind
);
    p_inc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_kind == SQ_INC && !instr_load && !stall)
        |=> (upc == UPC_W'($past(upc) + 1'b1)));

    p_load_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_load && !stall)
        |=> (upc[UPC_W-1:START_SH] == $past(opcode)));

    p_end_home_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (end_instr && !instr_load && !stall) |=> (upc == '0));

    p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> $stable(upc));

    p_mem_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_rd, mem_wr, mem_wait}));

    p_group_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($onehot0(alu_op) && $onehot0(src_oe) && $onehot0(dst_ld)));
endmodule

bind microseq microseq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .stall      (stall),
    .instr_load (instr_load),
    .opcode     (opcode),
    .upc        (upc),
    .alu_op     (alu_op),
    .src_oe     (src_oe),
    .dst_ld     (dst_ld),
    .mem_rd     (mem_rd),
    .mem_wr     (mem_wr),
    .mem_wait   (mem_wait),
    .end_instr  (end_instr),
    .seq_kind   (cur_seq)
);

// File: tb/microseq_tb.sv
`timescale 1ns/1ps
module microseq_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       stall = 1'b0;
    logic       instr_load = 1'b0;
    logic [3:0] opcode = '0;
    logic [1:0] mode = '0;
    logic [3:0] cond_flags = '0;
    logic [5:0] upc;
    logic [6:0] alu_op, src_oe, dst_ld;
    logic       mem_rd, mem_wr, mem_wait, end_instr;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    microseq u_dut (
        .clk(clk), .rst_n(rst_n), .stall(stall), .instr_load(instr_load),
        .opcode(opcode), .mode(mode), .cond_flags(cond_flags), .upc(upc),
        .alu_op(alu_op), .src_oe(src_oe), .dst_ld(dst_ld), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .mem_wait(mem_wait), .end_instr(end_instr)
    );

    task automatic check(string req, int act, int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        stall = 0; instr_load = 0; opcode = 0; mode = 0; cond_flags = 0;
        rst_n = 0;
        tick();
        rst_n = 1;
    endtask

    task automatic dispatch(int op, int md);
        do_reset();
        tick(); tick();
        opcode = 4'(op); mode = 2'(md); instr_load = 1;
        tick();
        instr_load = 0;
    endtask

    task automatic t_reset_state();
        do_reset();
        check("R1 upc", upc, 0);
        check("R1 mem_rd", mem_rd, 1);
        check("R1 src_oe", src_oe, 1);
        check("R1 dst_ld", dst_ld, 1);
        check("R1 alu_op", alu_op, 0);
        check("R1 end_instr", end_instr, 0);
    endtask

    task automatic t_fetch_walk();
        do_reset();
        tick();
        check("R2 upc step", upc, 1);
        check("R8 mem_wait", mem_wait, 1);
        check("R8 mem_rd off", mem_rd, 0);
        check("R9 src none", src_oe, 0);
        tick();
        check("R9 src word2", src_oe, 2);
        check("R9 dst word2", dst_ld, 2);
        tick();
        check("R6 end word3", end_instr, 1);
        tick();
        check("R6 home", upc, 0);
    endtask

    task automatic t_dispatch_run();
        dispatch(1, 0);
        check("R3 start", upc, 4);
        check("R10 src", src_oe, 4);
        check("R10 dst", dst_ld, 4);
        tick();
        check("R10 alu add", alu_op, 1);
        check("R10 dst Z", dst_ld, 8);
        tick();
        check("R10 end", end_instr, 1);
        check("R10 src", src_oe, 16);
        opcode = 2; instr_load = 1;
        tick();
        instr_load = 0;
        check("R3 load over end", upc, 8);
        cond_flags = 4'b1110;
        tick();
        check("R5 not taken", upc, 9);
        check("R11 alu sub", alu_op, 2);
        check("R8 mem_wr", mem_wr, 1);
        check("R8 mem_rd excl", mem_rd, 0);
        tick();
        check("R6 home after 9", upc, 0);
    endtask

    task automatic t_mode_skip();
        dispatch(1, 1);
        check("R3 mode or skip", upc, 5);
        check("R10 alu at 5", alu_op, 1);
    endtask

    task automatic t_branch_taken();
        dispatch(2, 0);
        cond_flags = 4'b0001;
        check("R11 at 8", upc, 8);
        tick();
        check("R5 taken", upc, 12);
        check("R11 dst", dst_ld, 32);
        check("R11 end", end_instr, 1);
    endtask

    task automatic t_jump_or();
        dispatch(4, 0);
        check("R12 at 16", upc, 16);
        mode = 3;
        tick();
        check("R4 jump or 3", upc, 23);
        check("R12 dst", dst_ld, 8);
        dispatch(4, 0);
        mode = 1;
        tick();
        check("R4 jump or 1", upc, 21);
        check("R12 dst", dst_ld, 2);
    endtask

    task automatic t_stall();
        do_reset();
        tick();
        stall = 1; instr_load = 1; opcode = 5;
        tick(); tick(); tick();
        check("R7 hold", upc, 1);
        check("R7 outputs kept", mem_wait, 1);
        stall = 0; instr_load = 0;
        tick();
        check("R7 resume", upc, 2);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_fetch_walk();
        t_dispatch_run();
        t_mode_skip();
        t_branch_taken();
        t_jump_or();
        t_stall();
        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule